// File: doc/BRIEF.md
# Host Port Acknowledge Controller

This block sits on the slave side of an asynchronous host bus and decides, for each host read, write or address strobe, when the host may end it. It drives a single acknowledge line whose active level is strapped during reset. That line follows one of two handshakes. In acknowledge mode the line pulses active once an access can finish. In ready mode the line rests active and drops to insert wait states.

Host data is 8 or 16 bits wide per beat. One, two or three beats are packed, low lane first, into a word of up to 24 bits, and that word is exchanged with internal memory over a request/done port. A write is posted to memory on the beat that completes a word. A read fetches the whole word on its first beat and serves later beats from a local buffer. The host strobes are asynchronous and active low. Each one passes through a two-flop synchronizer before its leading edge is detected.

Top module: `hpack_ctrl`

## Requirements
- R1: The active level of the acknowledge line equals the value on `strap_pol_i` during reset. That value reads back in config bit 5, and config writes never change it.
- R2: Config bits [7:6] form the handshake mode field. Bit 7 resets to 0. Bit 6 resets to 1 when `strap_pol_i` and `strap_ack_i` are equal during reset and to 0 when they differ. Bit 6 = 1 selects ready mode and bit 6 = 0 selects acknowledge mode. The reset readback is {0, pol XNOR ack, pol, 1, 0, 3'b011}.
- R3: A config write stores bits [7:6], bit 4 (address-cycle acknowledge enable), bit 3 (1 = 16-bit host beats, 0 = 8-bit) and bits [2:0] (beats per word: 0 or 1 means 1, and 2 or more means 2 or 3, capped at 3). Bit 5 is ignored.
- R4: In acknowledge mode the line is inactive between strobes. It goes active only after the strobe's leading edge, once the access can finish, and goes inactive again after the host removes the strobe.
- R5: In ready mode the line is active between strobes. It goes inactive while an internal access is pending and returns to active when that access finishes. The host holds each strobe for at least 4 clocks before it samples the line.
- R6: Write beat k places its data at bits [8k+7:8k] for 8-bit beats or [16k+15:16k] for 16-bit beats. Bits above 23 are discarded. The last beat of a word issues one internal write of the assembled 24-bit word.
- R7: The first read beat of a word issues one internal read. Read beat k then returns the lane-k slice of the fetched word on `hdata_o`, using the same lane layout as R6. Later read beats issue no internal request.
- R8: A beat that neither starts a read nor completes a write is acknowledged without any internal request. A beat that does start a read or complete a write is acknowledged only after `mem_done_i` has been seen.
- R9: When config bit 4 is 1, an address strobe is acknowledged at once with no internal access. When bit 4 is 0, an address strobe is not acknowledged.
- R10: `mem_req_o` stays high from its rise until `mem_done_i` is seen, and `mem_we_o` and `mem_wdata_o` stay stable for that whole time.
- R11: The beat counter returns to zero on reset and after each completed word. A partial word held at reset is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| strap_pol_i | input | 1 | Acknowledge polarity strap (1 = active high) |
| strap_ack_i | input | 1 | Level on the acknowledge pin during reset, used for mode strapping |
| hwr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| hrd_n_i | input | 1 | Host read strobe, active low, asynchronous |
| hadr_n_i | input | 1 | Host address-cycle strobe, active low, asynchronous |
| hdata_i | input | 16 | Host write data |
| hdata_o | output | 16 | Host read data for the current beat |
| hack_o | output | 1 | Acknowledge / ready line |
| cfg_we_i | input | 1 | Config register write strobe |
| cfg_wdata_i | input | 8 | Config write data |
| cfg_rdata_o | output | 8 | Config register readback |
| mem_req_o | output | 1 | Internal memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_wdata_o | output | 24 | Assembled write word |
| mem_rdata_i | input | 24 | Read word from memory, valid with done |
| mem_done_i | input | 1 | Internal access finished |

## Verification
On every cycle the embedded properties check the following. The request is held, with its data and direction stable, until done arrives. The line is never active while an internal access is still waiting for done. The mode bits come out of reset as the straps dictate, the polarity bit survives config writes, and the beat counter stays in range. Only the bench's scenarios can show the rest. These are the lane placement and truncation of assembled words, read slices served from the buffer, the difference between the two handshakes at the pin, address-cycle handling with the enable on and off, and a partial word thrown away by a second reset under the opposite polarity.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  localparam int STB_WR = 0;
  localparam int STB_RD = 1;
  localparam int STB_AD = 2;
  localparam int NSTB   = 3;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_ACKD = 2'd2
  } st_t;
endpackage

// File: rtl/hpa_sync.sv
module hpa_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] strb_n_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_chan
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= strb_n_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign fall_o[g] = s3_q & ~s2_q;
  end
endmodule

// File: rtl/hpa_cfg.sv
module hpa_cfg #(
  parameter int MAXB = 3,
  localparam int BCW = $clog2(MAXB + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           strap_pol_i,
  input  logic           strap_ack_i,
  input  logic           we_i,
  input  logic [7:0]     wdata_i,
  output logic [7:0]     rdata_o,
  output logic           pol_o,
  output logic           ready_o,
  output logic           acc_o,
  output logic           w16_o,
  output logic [BCW-1:0] beats_o
);
  localparam logic [7:0] WMASK = 8'b1101_1111;

  logic [7:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst)
      reg_q <= {1'b0, ~(strap_pol_i ^ strap_ack_i), strap_pol_i, 1'b1, 1'b0, 3'd3};
    else if (we_i)
      reg_q <= (wdata_i & WMASK) | (reg_q & ~WMASK);
  end

  always_comb begin
    int f;
    f = int'(reg_q[2:0]);
    if (f < 1) f = 1;
    if (f > MAXB) f = MAXB;
    beats_o = BCW'(f);
  end

  assign rdata_o = reg_q;
  assign pol_o   = reg_q[5];
  assign ready_o = reg_q[6];
  assign acc_o   = reg_q[4];
  assign w16_o   = reg_q[3];

  a_r2_strap_mode: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (reg_q[7] == 1'b0) && (reg_q[6] == $past(~(strap_pol_i ^ strap_ack_i))));
  a_r1_pol_kept: assert property (@(posedge clk) disable iff (rst)
    we_i |=> rdata_o[5] == $past(rdata_o[5]));
  a_r3_mode_write: assert property (@(posedge clk) disable iff (rst)
    we_i |=> rdata_o[7:6] == $past(wdata_i[7:6]));
endmodule

// File: rtl/hpa_engine.sv
module hpa_engine
  import hpa_pkg::*;
#(
  parameter int HW   = 16,
  parameter int MW   = 24,
  parameter int MAXB = 3,
  localparam int BW  = HW / 2,
  localparam int BCW = $clog2(MAXB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSTB-1:0] lvl_i,
  input  logic [NSTB-1:0] fall_i,
  input  logic [HW-1:0]   hdata_i,
  input  logic            pol_i,
  input  logic            ready_i,
  input  logic            acc_i,
  input  logic            w16_i,
  input  logic [BCW-1:0]  beats_i,
  output logic [HW-1:0]   hdata_o,
  output logic            hack_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [MW-1:0]   mem_wdata_o,
  input  logic [MW-1:0]   mem_rdata_i,
  input  logic            mem_done_i
);
  st_t            st_q, st_n;
  logic [BCW-1:0] cnt_q;
  logic [MW-1:0]  asm_q, rbuf_q, wdat_q;
  logic           rvalid_q, req_q, we_q, act_q;
  logic [HW-1:0]  hdo_q;

  function automatic logic [MW-1:0] merge(input logic [MW-1:0] base,
                                          input logic [HW-1:0] d,
                                          input int idx, input logic w16);
    logic [MW-1:0] r;
    r = base;
    for (int i = 0; i < MW; i++) begin
      if (w16) begin
        if (i / HW == idx) r[i] = d[i % HW];
      end else begin
        if (i / BW == idx) r[i] = d[i % BW];
      end
    end
    return r;
  endfunction

  function automatic logic [HW-1:0] pick(input logic [MW-1:0] word,
                                         input int idx, input logic w16);
    logic [HW-1:0] r;
    int p;
    r = '0;
    for (int j = 0; j < HW; j++) begin
      p = w16 ? idx * HW + j : idx * BW + j;
      if ((w16 || j < BW) && p < MW) r[j] = word[p];
    end
    return r;
  endfunction

  logic           go_ad, go_wr, go_rd, rel;
  logic [BCW-1:0] cnt_eff;
  logic           last;

  assign go_ad   = (st_q == S_IDLE) && fall_i[STB_AD] && acc_i;
  assign go_wr   = (st_q == S_IDLE) && !go_ad && fall_i[STB_WR];
  assign go_rd   = (st_q == S_IDLE) && !go_ad && !fall_i[STB_WR] && fall_i[STB_RD];
  assign rel     = lvl_i[STB_WR] && lvl_i[STB_RD] && (lvl_i[STB_AD] || !acc_i);
  assign cnt_eff = rvalid_q ? '0 : cnt_q;
  assign last    = (int'(cnt_eff) + 1) >= int'(beats_i);

  always_comb begin
    st_n = st_q;
    case (st_q)
      S_IDLE: begin
        if (go_ad)      st_n = S_ACKD;
        else if (go_wr) st_n = last ? S_WAIT : S_ACKD;
        else if (go_rd) st_n = rvalid_q ? S_ACKD : S_WAIT;
      end
      S_WAIT:  if (mem_done_i) st_n = S_ACKD;
      S_ACKD:  if (rel) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      asm_q    <= '0;
      rbuf_q   <= '0;
      wdat_q   <= '0;
      rvalid_q <= 1'b0;
      req_q    <= 1'b0;
      we_q     <= 1'b0;
      hdo_q    <= '0;
      act_q    <= 1'b0;
    end else begin
      st_q  <= st_n;
      act_q <= ready_i ? (st_n != S_WAIT) : (st_n == S_ACKD);
      if (go_wr) begin
        rvalid_q <= 1'b0;
        if (last) begin
          req_q  <= 1'b1;
          we_q   <= 1'b1;
          wdat_q <= merge(asm_q, hdata_i, int'(cnt_eff), w16_i);
        end else begin
          asm_q <= merge(rvalid_q ? '0 : asm_q, hdata_i, int'(cnt_eff), w16_i);
          cnt_q <= cnt_eff + 1'b1;
        end
      end else if (go_rd) begin
        if (!rvalid_q) begin
          req_q <= 1'b1;
          we_q  <= 1'b0;
          asm_q <= '0;
        end else begin
          hdo_q <= pick(rbuf_q, int'(cnt_q), w16_i);
          if ((int'(cnt_q) + 1) >= int'(beats_i)) begin
            cnt_q    <= '0;
            rvalid_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
      if (st_q == S_WAIT && mem_done_i) begin
        req_q <= 1'b0;
        if (we_q) begin
          cnt_q <= '0;
          asm_q <= '0;
        end else begin
          rbuf_q <= mem_rdata_i;
          hdo_q  <= pick(mem_rdata_i, 0, w16_i);
          if (int'(beats_i) <= 1) begin
            cnt_q    <= '0;
            rvalid_q <= 1'b0;
          end else begin
            cnt_q    <= BCW'(1);
            rvalid_q <= 1'b1;
          end
        end
      end
    end
  end

  assign hack_o      = ~(act_q ^ pol_i);
  assign hdata_o     = hdo_q;
  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wdat_q;

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_done_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_wdata_o));
  a_r8_no_early_ack: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_done_i |=> !act_q);
  a_r11_cnt_range: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < MAXB);
endmodule

// File: rtl/hpack_ctrl.sv
module hpack_ctrl
  import hpa_pkg::*;
#(
  parameter int HW   = 16,
  parameter int MW   = 24,
  parameter int MAXB = 3,
  localparam int BCW = $clog2(MAXB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strap_pol_i,
  input  logic          strap_ack_i,
  input  logic          hwr_n_i,
  input  logic          hrd_n_i,
  input  logic          hadr_n_i,
  input  logic [HW-1:0] hdata_i,
  output logic [HW-1:0] hdata_o,
  output logic          hack_o,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_wdata_i,
  output logic [7:0]    cfg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [MW-1:0] mem_wdata_o,
  input  logic [MW-1:0] mem_rdata_i,
  input  logic          mem_done_i
);
  logic [NSTB-1:0] strb_n, lvl, fall;
  logic            pol, ready, acc, w16;
  logic [BCW-1:0]  beats;

  always_comb begin
    strb_n         = '1;
    strb_n[STB_WR] = hwr_n_i;
    strb_n[STB_RD] = hrd_n_i;
    strb_n[STB_AD] = hadr_n_i;
  end

  hpa_sync #(.N(NSTB)) u_sync (
    .clk(clk), .rst(rst), .strb_n_i(strb_n), .lvl_o(lvl), .fall_o(fall)
  );

  hpa_cfg #(.MAXB(MAXB)) u_cfg (
    .clk(clk), .rst(rst), .strap_pol_i(strap_pol_i), .strap_ack_i(strap_ack_i),
    .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .pol_o(pol), .ready_o(ready), .acc_o(acc), .w16_o(w16), .beats_o(beats)
  );

  hpa_engine #(.HW(HW), .MW(MW), .MAXB(MAXB)) u_eng (
    .clk(clk), .rst(rst), .lvl_i(lvl), .fall_i(fall), .hdata_i(hdata_i),
    .pol_i(pol), .ready_i(ready), .acc_i(acc), .w16_i(w16), .beats_i(beats),
    .hdata_o(hdata_o), .hack_o(hack_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_done_i(mem_done_i)
  );
endmodule

// File: tb/hpack_ctrl_bench.sv
`timescale 1ns/1ps
module hpack_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_pol = 1'b1, strap_ack = 1'b1;
  logic hwr_n = 1'b1, hrd_n = 1'b1, hadr_n = 1'b1;
  logic [15:0] hdata_i = '0;
  logic [15:0] hdata_o;
  logic hack;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic mem_req, mem_we;
  logic [23:0] mem_wdata;
  logic [23:0] rd_word = '0;
  logic mem_done = 1'b0;

  int errors = 0, checks = 0;
  bit finished = 0;
  bit done_seen = 0;
  bit ready_mode = 1;
  logic act_lvl = 1'b1;
  logic [23:0] exp_q[$];

  always #4 clk = ~clk;

  hpack_ctrl u_hpack_ctrl (
    .clk(clk), .rst(rst), .strap_pol_i(strap_pol), .strap_ack_i(strap_ack),
    .hwr_n_i(hwr_n), .hrd_n_i(hrd_n), .hadr_n_i(hadr_n), .hdata_i(hdata_i),
    .hdata_o(hdata_o), .hack_o(hack), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rd_word), .mem_done_i(mem_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and write scoreboard (R6, R10)
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (mem_we) begin
          if (exp_q.size() == 0) chk(0, "R6 unexpected write", {8'h0, mem_wdata}, 32'h0);
          else begin
            logic [23:0] e;
            e = exp_q.pop_front();
            chk(mem_wdata == e, "R6 write word", {8'h0, mem_wdata}, {8'h0, e});
          end
        end
        repeat (6) @(negedge clk);
        chk(mem_req == 1'b1, "R10 request held", {31'h0, mem_req}, 32'h1);
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
        done_seen = 1;
        while (mem_req) @(negedge clk);
      end
    end
  end

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic pol, input logic ack);
    @(negedge clk);
    strap_pol = pol; strap_ack = ack; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    act_lvl = pol;
    repeat (3) @(negedge clk);
  endtask

  // kind 0 write, 1 read, 2 address
  task automatic beat(input int kind, input logic [15:0] d, input bit compl,
                      input logic [15:0] exp_rd, input string tag);
    int n;
    done_seen = 0;
    @(negedge clk);
    hdata_i = d;
    if (kind == 0) hwr_n = 1'b0;
    else if (kind == 1) hrd_n = 1'b0;
    else hadr_n = 1'b0;
    repeat (4) @(negedge clk);
    if (compl) chk(hack != act_lvl, {tag, " R5/R4 wait state"}, {31'h0, hack}, {31'h0, ~act_lvl});
    n = 0;
    while (hack != act_lvl && n < 60) begin @(negedge clk); n++; end
    chk(hack == act_lvl, {tag, " R8 acknowledged"}, {31'h0, hack}, {31'h0, act_lvl});
    if (compl) chk(done_seen == 1, {tag, " R8 ack after done"}, {31'h0, done_seen}, 32'h1);
    else chk(done_seen == 0 && mem_req == 0, {tag, " R8 no internal access"},
             {30'h0, done_seen, mem_req}, 32'h0);
    if (kind == 1) chk(hdata_o == exp_rd, {tag, " R7 read slice"}, {16'h0, hdata_o}, {16'h0, exp_rd});
    hwr_n = 1'b1; hrd_n = 1'b1; hadr_n = 1'b1;
    repeat (6) @(negedge clk);
    if (ready_mode) chk(hack == act_lvl, {tag, " R5 idle active"}, {31'h0, hack}, {31'h0, act_lvl});
    else chk(hack != act_lvl, {tag, " R4 released"}, {31'h0, hack}, {31'h0, ~act_lvl});
  endtask

  initial begin
    do_reset(1'b1, 1'b1);
    chk(cfg_rdata == 8'h73, "R2 reset readback equal straps", {24'h0, cfg_rdata}, 32'h73);
    chk(hack == 1'b1, "R1 R5 idle line active high", {31'h0, hack}, 32'h1);

    // ready mode, 8-bit, 3 beats
    ready_mode = 1;
    exp_q.push_back(24'hCCBBAA);
    beat(0, 16'h00AA, 0, 0, "R6 wr b0");
    beat(0, 16'h00BB, 0, 0, "R6 wr b1");
    beat(0, 16'h00CC, 1, 0, "R6 wr b2");
    rd_word = 24'h123456;
    beat(1, 0, 1, 16'h0056, "R7 rd b0");
    beat(1, 0, 0, 16'h0034, "R7 rd b1");
    beat(1, 0, 0, 16'h0012, "R7 rd b2");

    // ack mode, 16-bit, 2 beats; bit 5 written 0 must stay 1
    cfg_write(8'h1A);
    chk(cfg_rdata == 8'h3A, "R1 R3 config write", {24'h0, cfg_rdata}, 32'h3A);
    ready_mode = 0;
    @(negedge clk);
    chk(hack == 1'b0, "R4 idle inactive", {31'h0, hack}, 32'h0);
    exp_q.push_back(24'h12BEEF);
    beat(0, 16'hBEEF, 0, 0, "R6 wr16 b0");
    beat(0, 16'hFF12, 1, 0, "R6 wr16 b1 truncation");
    rd_word = 24'hA5C3E1;
    beat(1, 0, 1, 16'hC3E1, "R7 rd16 b0");
    beat(1, 0, 0, 16'h00A5, "R7 rd16 b1");
    beat(2, 0, 0, 0, "R9 address cycle");

    // one beat per word
    cfg_write(8'h11);
    exp_q.push_back(24'h00007E);
    beat(0, 16'h007E, 1, 0, "R3 single beat");

    // address cycles ignored when disabled
    cfg_write(8'h01);
    done_seen = 0;
    @(negedge clk); hadr_n = 1'b0;
    repeat (10) @(negedge clk);
    chk(hack == 1'b0 && mem_req == 0, "R9 address cycle not acked", {30'h0, hack, mem_req}, 32'h0);
    hadr_n = 1'b1;
    repeat (4) @(negedge clk);

    // partial word, then reset with opposite polarity
    cfg_write(8'h13);
    beat(0, 16'h0099, 0, 0, "R11 partial");
    do_reset(1'b0, 1'b1);
    chk(cfg_rdata == 8'h13, "R2 reset readback differing straps", {24'h0, cfg_rdata}, 32'h13);
    chk(hack == 1'b1, "R1 active low idle inactive", {31'h0, hack}, 32'h1);
    exp_q.push_back(24'h030201);
    beat(0, 16'h0001, 0, 0, "R11 wr b0");
    beat(0, 16'h0002, 0, 0, "R11 wr b1");
    beat(0, 16'h0003, 1, 0, "R11 wr b2");
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule